// File: doc/BRIEF.md
# QR Decomposition Instruction Sequencer

This block is the control unit that drives a two-pass Gram-Schmidt QR factorisation of a ROWS x COLS matrix onto two external execution units: a vector multiply/accumulate unit and a divide/square-root unit. It walks the column indices, builds one instruction per cycle, and splits every column-wide operation into ROWS/VEC beats for a vector datapath of width VEC. It computes no arithmetic itself.

The first pass uses only squared column norms and dot products that are not normalised, so no square root sits on the critical path. For each column k it issues a self dot product, then dot products against every later column, then a subtract update of every later column. The second pass then forms the square roots, the scaled R entries and the Q columns. Instruction issue stops while the fill level of the result FIFO between the units is at or above a threshold. While an instruction is not taken, the instruction stays stable.

Top module: `qr_seq`

## Requirements
- R1: While reset is high and after it falls, busy, ins_valid and done are 0 until a start is seen.
- R2: A start pulse in idle makes busy high at the next clock edge. The first instruction is op 00 (self-norm) with k=0, j=0, beat 0, scalar 0.
- R3: For each column k in ascending order, pass one issues the self-norm (op 00, j=k), then op 01 (dot) for each j from k+1 to COLS-1 ascending, then op 11 (subtract update) for each j from k+1 to COLS-1 ascending.
- R4: Every column-wide instruction (ops 00, 01, 11 and the Q-column divide) is issued as ROWS/VEC consecutive beats, beat field 0 first, with the other fields unchanged.
- R5: The second pass starts only after pass one is complete. For each k ascending it issues a square root (op 10, scalar 1, j=k), then scalar divides (op 10, scalar 1) for j from k+1 ascending, then the Q-column divide (op 10, scalar 0, j=k) in beats.
- R6: ins_valid is high exactly when busy is high and fifo_level is below THRESH. A level equal to THRESH blocks issue.
- R7: An instruction is accepted on a clock edge where ins_valid and ins_ready are both high. Without acceptance, ins_op, ins_k, ins_j, ins_beat and ins_scalar hold their values.
- R8: After the final Q-column beat of the last column is accepted, done is high for exactly one cycle following that edge, and busy is low from that same cycle. The total instruction count is COLS*B + COLS*(COLS-1)*B + COLS + COLS*(COLS-1)/2 + COLS*B, where B = ROWS/VEC.
- R9: A start pulse while busy has no effect on the instruction stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a factorisation (sampled in idle only) |
| ins_ready | input | 1 | Execution side takes the instruction this cycle |
| fifo_level | input | LVL_W | Fill level of the result FIFO |
| ins_valid | output | 1 | Instruction presented and issue not throttled |
| ins_op | output | 2 | 00 self-norm, 01 dot, 10 divide/root, 11 subtract update |
| ins_k | output | KW | Pivot column index |
| ins_j | output | KW | Second column index |
| ins_beat | output | BW | Vector beat within the column |
| ins_scalar | output | 1 | Divide/root on a single scalar rather than a column |
| busy | output | 1 | Factorisation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
ins_valid follows fifo_level and ins_ready in the same cycle. The instruction fields change one clock edge after an acceptance, and done and the fall of busy come one edge after the last acceptance. The bench therefore drives its inputs at the falling edge and samples 1 ns later. At that point it judges ins_valid against the level it has just driven and compares the fields with the next entry of its expected stream. After the final acceptance it checks done at the following falling edge, and checks its drop at the one after.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  typedef enum logic [1:0] {
    OP_NORM = 2'b00,
    OP_DOT  = 2'b01,
    OP_DIV  = 2'b10,
    OP_SUB  = 2'b11
  } qrs_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_NORM,
    PH_DOT,
    PH_SUB,
    PH_ROOT,
    PH_RDIV,
    PH_QCOL
  } qrs_phase_e;
endpackage

// File: rtl/qrs_beat_ctr.sv
module qrs_beat_ctr #(
  parameter int BEATS = 2,
  parameter int BW    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [BW-1:0] beat,
  output logic          last
);
  localparam logic [BW-1:0] TOP = BW'(BEATS - 1);

  assign last = (beat == TOP);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      beat <= '0;
    end else if (step) begin
      beat <= last ? '0 : beat + BW'(1);
    end
  end
endmodule

// File: rtl/qrs_walker.sv
module qrs_walker
  import qrs_pkg::*;
#(
  parameter int COLS = 3,
  parameter int KW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          fire_i,
  input  logic          beat_last_i,
  output qrs_phase_e    phase_o,
  output logic [KW-1:0] k_o,
  output logic [KW-1:0] j_o,
  output logic          finish_o
);
  localparam logic [KW-1:0] LAST = KW'(COLS - 1);

  qrs_phase_e    ph_n;
  logic [KW-1:0] k_n, j_n;
  logic          col_end;

  assign col_end = fire_i && beat_last_i;

  always_comb begin
    ph_n     = phase_o;
    k_n      = k_o;
    j_n      = j_o;
    finish_o = 1'b0;
    case (phase_o)
      PH_IDLE: if (start_i) begin
        ph_n = PH_NORM;
        k_n  = '0;
        j_n  = '0;
      end
      PH_NORM: if (col_end) begin
        if (k_o == LAST) begin
          ph_n = PH_ROOT;
          k_n  = '0;
          j_n  = '0;
        end else begin
          ph_n = PH_DOT;
          j_n  = k_o + KW'(1);
        end
      end
      PH_DOT: if (col_end) begin
        if (j_o == LAST) begin
          ph_n = PH_SUB;
          j_n  = k_o + KW'(1);
        end else begin
          j_n = j_o + KW'(1);
        end
      end
      PH_SUB: if (col_end) begin
        if (j_o == LAST) begin
          ph_n = PH_NORM;
          k_n  = k_o + KW'(1);
          j_n  = k_o + KW'(1);
        end else begin
          j_n = j_o + KW'(1);
        end
      end
      PH_ROOT: if (fire_i) begin
        if (k_o == LAST) begin
          ph_n = PH_QCOL;
          j_n  = k_o;
        end else begin
          ph_n = PH_RDIV;
          j_n  = k_o + KW'(1);
        end
      end
      PH_RDIV: if (fire_i) begin
        if (j_o == LAST) begin
          ph_n = PH_QCOL;
          j_n  = k_o;
        end else begin
          j_n = j_o + KW'(1);
        end
      end
      PH_QCOL: if (col_end) begin
        if (k_o == LAST) begin
          ph_n     = PH_IDLE;
          k_n      = '0;
          j_n      = '0;
          finish_o = 1'b1;
        end else begin
          ph_n = PH_ROOT;
          k_n  = k_o + KW'(1);
          j_n  = k_o + KW'(1);
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= PH_IDLE;
      k_o     <= '0;
      j_o     <= '0;
    end else begin
      phase_o <= ph_n;
      k_o     <= k_n;
      j_o     <= j_n;
    end
  end
endmodule

// File: rtl/qr_seq.sv
module qr_seq
  import qrs_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 3,
  parameter int VEC    = 4,
  parameter int LVL_W  = 4,
  parameter int THRESH = 12,
  localparam int BEATS = ROWS / VEC,
  localparam int KW    = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ins_ready,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             ins_valid,
  output logic [1:0]       ins_op,
  output logic [KW-1:0]    ins_k,
  output logic [KW-1:0]    ins_j,
  output logic [BW-1:0]    ins_beat,
  output logic             ins_scalar,
  output logic             busy,
  output logic             done
);
  qrs_phase_e phase;
  logic       fire, vec_phase, beat_last, finish, below;

  assign below     = ({1'b0, fifo_level} < (LVL_W + 1)'(THRESH));
  assign busy      = (phase != PH_IDLE);
  assign ins_valid = busy && below;
  assign fire      = ins_valid && ins_ready;
  assign vec_phase = (phase == PH_NORM) || (phase == PH_DOT) ||
                     (phase == PH_SUB)  || (phase == PH_QCOL);

  qrs_beat_ctr #(.BEATS(BEATS), .BW(BW)) u_beat (
    .clk  (clk),
    .rst  (rst),
    .clear(start && !busy),
    .step (fire && vec_phase),
    .beat (ins_beat),
    .last (beat_last)
  );

  qrs_walker #(.COLS(COLS), .KW(KW)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .fire_i     (fire),
    .beat_last_i(beat_last),
    .phase_o    (phase),
    .k_o        (ins_k),
    .j_o        (ins_j),
    .finish_o   (finish)
  );

  always_comb begin
    case (phase)
      PH_DOT:  ins_op = OP_DOT;
      PH_SUB:  ins_op = OP_SUB;
      PH_ROOT,
      PH_RDIV,
      PH_QCOL: ins_op = OP_DIV;
      default: ins_op = OP_NORM;
    endcase
  end

  assign ins_scalar = (phase == PH_ROOT) || (phase == PH_RDIV);

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= finish;
  end
endmodule

// File: rtl/qr_seq_chk.sv
module qr_seq_chk #(
  parameter int KW     = 2,
  parameter int BW     = 1,
  parameter int LVL_W  = 4,
  parameter int BEATS  = 2,
  parameter int THRESH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_ready,
  input logic [LVL_W-1:0] fifo_level,
  input logic             ins_valid,
  input logic [1:0]       ins_op,
  input logic [KW-1:0]    ins_k,
  input logic [KW-1:0]    ins_j,
  input logic [BW-1:0]    ins_beat,
  input logic             ins_scalar,
  input logic             busy,
  input logic             done
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ins_valid);

  p_first_instr_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (ins_op == 2'b00 && ins_k == '0 && ins_j == '0 &&
                     ins_beat == '0 && !ins_scalar));

  p_beat_range_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (32'(ins_beat) < BEATS));

  p_scalar_div_r5: assert property (@(posedge clk) disable iff (rst)
    ins_scalar |-> (ins_op == 2'b10 && ins_beat == '0));

  p_full_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (32'(fifo_level) >= THRESH) |-> !ins_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !(ins_valid && ins_ready)) |=>
      ($stable(ins_op) && $stable(ins_k) && $stable(ins_j) &&
       $stable(ins_beat) && $stable(ins_scalar) && busy));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind qr_seq qr_seq_chk #(
  .KW(KW), .BW(BW), .LVL_W(LVL_W), .BEATS(BEATS), .THRESH(THRESH)
) u_chk (
  .clk(clk), .rst(rst), .ins_ready(ins_ready), .fifo_level(fifo_level),
  .ins_valid(ins_valid), .ins_op(ins_op), .ins_k(ins_k), .ins_j(ins_j),
  .ins_beat(ins_beat), .ins_scalar(ins_scalar), .busy(busy), .done(done)
);

// File: tb/qr_seq_tb.sv
`timescale 1ns/1ps
module qr_seq_tb;
  localparam int ROWS = 8, COLS = 3, VEC = 4, LVL_W = 4, THRESH = 12;
  localparam int B = ROWS / VEC;
  localparam int KW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int BW = (B > 1) ? $clog2(B) : 1;

  // each row: {ready_every[3:0], full_every[3:0], mid_start[3:0]}
  localparam logic [11:0] ROWS_TBL [0:3] = '{
    12'h1_0_0, 12'h2_3_0, 12'h3_5_1, 12'h1_4_1
  };

  logic clk = 0, rst = 1, start = 0, ins_ready = 0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic ins_valid, ins_scalar, busy, done;
  logic [1:0] ins_op;
  logic [KW-1:0] ins_k, ins_j;
  logic [BW-1:0] ins_beat;

  int total = 0, bad = 0, n_exp = 0, cycles = 0;
  int e_op[0:127], e_k[0:127], e_j[0:127], e_b[0:127], e_s[0:127];

  always #2.5 clk = ~clk;

  qr_seq #(.ROWS(ROWS), .COLS(COLS), .VEC(VEC), .LVL_W(LVL_W), .THRESH(THRESH)) u_dut (
    .clk(clk), .rst(rst), .start(start), .ins_ready(ins_ready),
    .fifo_level(fifo_level), .ins_valid(ins_valid), .ins_op(ins_op),
    .ins_k(ins_k), .ins_j(ins_j), .ins_beat(ins_beat),
    .ins_scalar(ins_scalar), .busy(busy), .done(done));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int op, input int k, input int j, input int b, input int s);
    e_op[n_exp] = op; e_k[n_exp] = k; e_j[n_exp] = j; e_b[n_exp] = b; e_s[n_exp] = s;
    n_exp++;
  endtask

  task automatic build();
    n_exp = 0;
    for (int k = 0; k < COLS; k++) begin            // R3 pass one
      for (int b = 0; b < B; b++) push(0, k, k, b, 0);
      for (int j = k + 1; j < COLS; j++) for (int b = 0; b < B; b++) push(1, k, j, b, 0);
      for (int j = k + 1; j < COLS; j++) for (int b = 0; b < B; b++) push(3, k, j, b, 0);
    end
    for (int k = 0; k < COLS; k++) begin            // R5 pass two
      push(2, k, k, 0, 1);
      for (int j = k + 1; j < COLS; j++) push(2, k, j, 0, 1);
      for (int b = 0; b < B; b++) push(2, k, k, b, 0);
    end
  endtask

  task automatic run(input int rdy_every, input int full_every, input int mid_start);
    int idx = 0, cyc = 0;
    bit stall = 0;
    int sv_op = 0, sv_k = 0, sv_j = 0, sv_b = 0, sv_s = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    #1 chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    while (idx < n_exp && cyc < 3000) begin
      ins_ready = (cyc % rdy_every) == 0;
      if (full_every != 0 && (cyc % full_every) == 1) fifo_level = LVL_W'(THRESH);
      else fifo_level = (cyc % 2) ? '0 : LVL_W'(THRESH - 1);
      start = (mid_start != 0 && (cyc % 7) == 4);   // R9 ignored while busy
      #1;
      chk(ins_valid === (int'(fifo_level) < THRESH), "R6 valid vs level",
          int'(ins_valid), int'(int'(fifo_level) < THRESH));
      if (stall)
        chk(int'(ins_op) == sv_op && int'(ins_k) == sv_k && int'(ins_j) == sv_j &&
            int'(ins_beat) == sv_b && int'(ins_scalar) == sv_s, "R7 hold",
            int'(ins_op) * 1000 + int'(ins_k) * 100 + int'(ins_j) * 10 + int'(ins_beat),
            sv_op * 1000 + sv_k * 100 + sv_j * 10 + sv_b);
      if (ins_valid && ins_ready) begin
        chk(int'(ins_op) == e_op[idx] && int'(ins_k) == e_k[idx] && int'(ins_j) == e_j[idx] &&
            int'(ins_beat) == e_b[idx] && int'(ins_scalar) == e_s[idx],
            (e_op[idx] == 2) ? "R5 R4 pass two entry" : "R3 R4 pass one entry",
            int'(ins_op) * 10000 + int'(ins_k) * 1000 + int'(ins_j) * 100 + int'(ins_beat) * 10 + int'(ins_scalar),
            e_op[idx] * 10000 + e_k[idx] * 1000 + e_j[idx] * 100 + e_b[idx] * 10 + e_s[idx]);
        idx++;
        stall = 0;
      end else begin
        stall = 1;
        sv_op = int'(ins_op); sv_k = int'(ins_k); sv_j = int'(ins_j);
        sv_b = int'(ins_beat); sv_s = int'(ins_scalar);
      end
      if (idx < n_exp) chk(done === 1'b0, "R8 no early done", int'(done), 0);
      @(negedge clk);
      cyc++;
    end
    start = 0; ins_ready = 0;
    chk(idx == n_exp, "R8 instruction count", idx, n_exp);
    #1;
    chk(done === 1'b1 && busy === 1'b0, "R8 done after last", int'(done) * 10 + int'(busy), 10);
    @(negedge clk); #1;
    chk(done === 1'b0 && ins_valid === 1'b0, "R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    build();
    chk(n_exp == COLS * B + COLS * (COLS - 1) * B + COLS + COLS * (COLS - 1) / 2 + COLS * B,
        "R8 formula", n_exp, COLS * B + COLS * (COLS - 1) * B + COLS + COLS * (COLS - 1) / 2 + COLS * B);
    repeat (3) @(negedge clk);
    #1 chk(busy === 1'b0 && ins_valid === 1'b0 && done === 1'b0, "R1 in reset",
           int'(busy) + int'(ins_valid) + int'(done), 0);
    rst = 0;
    @(negedge clk); #1;
    chk(busy === 1'b0 && ins_valid === 1'b0 && done === 1'b0, "R1 after reset",
        int'(busy) + int'(ins_valid) + int'(done), 0);

    for (int r = 0; r < 4; r++)
      run(int'(ROWS_TBL[r][11:8]), int'(ROWS_TBL[r][7:4]), int'(ROWS_TBL[r][3:0]));

    // R6 boundary: level equal to THRESH blocks, one below passes
    @(negedge clk); start = 1; fifo_level = LVL_W'(THRESH); ins_ready = 1;
    @(negedge clk); start = 0; #1;
    chk(ins_valid === 1'b0, "R6 level at threshold", int'(ins_valid), 0);
    @(negedge clk); #1;
    chk(ins_valid === 1'b0 && ins_op == 2'b00 && ins_beat == '0, "R7 held while full",
        int'(ins_valid) * 10 + int'(ins_beat), 0);
    fifo_level = LVL_W'(THRESH - 1); #1;
    chk(ins_valid === 1'b1, "R6 level below threshold", int'(ins_valid), 1);
    // R1 reset mid-run
    ins_ready = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #1;
    chk(busy === 1'b0 && ins_valid === 1'b0, "R1 reset mid-run", int'(busy), 0);

    run(1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule